// File: doc/BRIEF.md
# Dynamic Cache-Fill Granularity Selector

This block decides how many bytes a DRAM cache controller should move on each fill from the large main memory behind it. Main-memory rows are grouped into row sets, and each access event names the row set it touched. Four fill sizes are candidates: 128 B, 256 B, 512 B and 2 KB. Row sets 0 to 3 are samplers, and each one always uses one candidate size. Every other row set uses whichever size scored best over the previous quantum.

Each candidate has a score. The score is the sum of the access latencies reported by that candidate's sampler set, plus a fixed cost for every access that caused a fill. This weighs slow accesses against the traffic that fills create. A free-running quantum timer fires every `QUANTUM_LEN` cycles. When it fires, the lowest score becomes the new winner and all scores restart. The controller presents a row-set index on the query port and gets back the size code to use for that set.

Top module: `fill_gran_selector`

## Requirements
- R1: After synchronous reset the winner is code 0, so every non-sampler set reports 0. Codes are 0 = 128 B, 1 = 256 B, 2 = 512 B, 3 = 2 KB.
- R2: A query for set index 0, 1, 2 or 3 always returns a code equal to that index, whatever the scores are.
- R3: A query for any set index of 4 or above returns the current winner code.
- R4: A valid event whose set index is below 4 adds its latency to that candidate's score. If its fill flag is 1, it also adds `FILL_COST`. Events on sets 4 and above leave every score unchanged.
- R5: Counting from the first clock edge after reset is released, the winner changes only on edge number k*`QUANTUM_LEN`. The new value is visible on the query port after that edge.
- R6: At a quantum boundary the candidate with the lowest score becomes the winner. If scores are equal, the smaller code wins.
- R7: At a boundary all scores restart. An event sampled on the boundary edge itself counts toward the new quantum only.
- R8: A score saturates at 2^`SCORE_W`-1 and does not wrap.
- R9: An event with the valid input low has no effect on any score.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Access event present this cycle |
| ev_set | input | SET_W | Row-set index of the event |
| ev_lat | input | LAT_W | Observed access latency of the event |
| ev_fill | input | 1 | Event caused a cache fill |
| q_set | input | SET_W | Row-set index being queried |
| q_gran | output | 2 | Fill-size code for the queried set |

## Verification
The bench plays a series of quanta, and each quantum's event mix is built so that a single fault changes the expected winner:
- A plain latency ranking checks the basic comparison.
- A quantum where fewer fills beat lower raw latency checks the fill cost.
- A quantum with four equal scores that are reached only if the scores were cleared and the boundary-edge event was carried over checks the restart rule.
- A quantum where a saturated score would win if it wrapped checks saturation.

Filler events on non-sampler sets and events with valid low are mixed into these quanta. The bench also reads the query port just before each boundary to confirm that the winner holds until the boundary. After the last quantum it confirms that the sampler sets still map to their fixed codes.

// File: rtl/gran_pkg.sv
package gran_pkg;

    localparam int NUM_CAND = 4;
    localparam int CODE_W   = 2;

    typedef enum logic [CODE_W-1:0] {
        GRAN_128B = 2'd0,
        GRAN_256B = 2'd1,
        GRAN_512B = 2'd2,
        GRAN_2KB  = 2'd3
    } gran_e;

    // Decoded view of one incoming event with respect to the sampler sets
    typedef struct packed {
        logic  hit;
        gran_e cand;
    } sample_t;

    function automatic gran_e to_gran(input logic [CODE_W-1:0] c);
        return gran_e'(c);
    endfunction

endpackage

// File: rtl/gran_quantum_timer.sv
module gran_quantum_timer #(
    parameter int QUANTUM_LEN = 4096
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (QUANTUM_LEN > 2) ? $clog2(QUANTUM_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUANTUM_LEN - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/gran_score_acc.sv
module gran_score_acc #(
    parameter int LAT_W     = 10,
    parameter int SCORE_W   = 20,
    parameter int FILL_COST = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               hit,
    input  logic [LAT_W-1:0]   lat,
    input  logic               fill,
    output logic [SCORE_W-1:0] score
);
    localparam int SUM_W = SCORE_W + 1;

    logic [SUM_W-1:0]   add_v;
    logic [SUM_W-1:0]   sum_v;
    logic [SCORE_W-1:0] base;
    logic [SCORE_W-1:0] nxt;

    always_comb begin
        add_v = SUM_W'(lat) + (fill ? SUM_W'(FILL_COST) : '0);
        base  = clear ? '0 : score;
        sum_v = {1'b0, base} + add_v;
        if (!hit)              nxt = base;
        else if (sum_v[SCORE_W]) nxt = '1;
        else                   nxt = sum_v[SCORE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) score <= '0;
        else     score <= nxt;
    end
endmodule

// File: rtl/gran_argmin.sv
module gran_argmin #(
    parameter int N     = 4,
    parameter int W     = 20,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0][W-1:0] vals,
    output logic [IDX_W-1:0]    idx
);
    logic [W-1:0] best_v;

    // Strict less-than keeps the earlier (smaller) index on ties
    always_comb begin
        best_v = vals[0];
        idx    = '0;
        for (int i = 1; i < N; i++) begin
            if (vals[i] < best_v) begin
                best_v = vals[i];
                idx    = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fill_gran_selector.sv
module fill_gran_selector
    import gran_pkg::*;
#(
    parameter int SET_W       = 8,
    parameter int LAT_W       = 10,
    parameter int SCORE_W     = 20,
    parameter int QUANTUM_LEN = 4096,
    parameter int FILL_COST   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [SET_W-1:0]  ev_set,
    input  logic [LAT_W-1:0]  ev_lat,
    input  logic              ev_fill,
    input  logic [SET_W-1:0]  q_set,
    output logic [CODE_W-1:0] q_gran
);
    localparam logic [SET_W-1:0] SAMPLER_LIM = SET_W'(NUM_CAND);

    logic                              tick;
    sample_t                           smp;
    logic [NUM_CAND-1:0][SCORE_W-1:0]  scores;
    logic [CODE_W-1:0]                 best_idx;
    gran_e                             winner;

    gran_quantum_timer #(.QUANTUM_LEN(QUANTUM_LEN)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    always_comb begin
        smp.hit  = ev_valid && (ev_set < SAMPLER_LIM);
        smp.cand = to_gran(ev_set[CODE_W-1:0]);
    end

    for (genvar c = 0; c < NUM_CAND; c++) begin : g_acc
        logic acc_hit;
        assign acc_hit = smp.hit && (smp.cand == to_gran(CODE_W'(c)));

        gran_score_acc #(
            .LAT_W     (LAT_W),
            .SCORE_W   (SCORE_W),
            .FILL_COST (FILL_COST)
        ) u_acc (
            .clk   (clk),
            .rst   (rst),
            .clear (tick),
            .hit   (acc_hit),
            .lat   (ev_lat),
            .fill  (ev_fill),
            .score (scores[c])
        );
    end

    gran_argmin #(.N(NUM_CAND), .W(SCORE_W), .IDX_W(CODE_W)) u_min (
        .vals (scores),
        .idx  (best_idx)
    );

    always_ff @(posedge clk) begin
        if (rst)       winner <= GRAN_128B;
        else if (tick) winner <= to_gran(best_idx);
    end

    assign q_gran = (q_set < SAMPLER_LIM) ? q_set[CODE_W-1:0] : winner;

endmodule

// File: rtl/fill_gran_checker.sv
module fill_gran_checker
    import gran_pkg::*;
#(
    parameter int SET_W   = 8,
    parameter int SCORE_W = 20
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             tick,
    input logic                             ev_valid,
    input logic [CODE_W-1:0]                winner,
    input logic [NUM_CAND-1:0][SCORE_W-1:0] scores,
    input logic [SET_W-1:0]                 q_set,
    input logic [CODE_W-1:0]                q_gran
);
    // R1: reset leaves the winner at the smallest size
    p_reset_win_r1: assert property (@(posedge clk)
        rst |=> (winner == '0));

    // R2: sampler sets keep their fixed code
    p_sampler_map_r2: assert property (@(posedge clk) disable iff (rst)
        (q_set < SET_W'(NUM_CAND)) |-> (q_gran == q_set[CODE_W-1:0]));

    // R5: the winner moves only on a quantum boundary
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(winner));

    // R7: an idle boundary leaves all scores at zero
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && !ev_valid) |=> (scores == '0));

    // R4: within a quantum a score never decreases
    for (genvar c = 0; c < NUM_CAND; c++) begin : g_mono
        p_grow_r4: assert property (@(posedge clk) disable iff (rst)
            !tick |=> (scores[c] >= $past(scores[c])));
    end
endmodule

bind fill_gran_selector fill_gran_checker #(
    .SET_W   (SET_W),
    .SCORE_W (SCORE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ev_valid (ev_valid),
    .winner   (winner),
    .scores   (scores),
    .q_set    (q_set),
    .q_gran   (q_gran)
);

// File: tb/fill_gran_selector_tb.sv
module fill_gran_selector_tb;

    localparam int SET_W   = 8;
    localparam int LAT_W   = 10;
    localparam int SCORE_W = 14;
    localparam int Q       = 64;
    localparam int FCOST   = 16;
    localparam int MAXS    = (1 << SCORE_W) - 1;
    localparam int OTHER   = 77;

    typedef struct {
        bit v;
        int set;
        int lat;
        bit fill;
    } ev_t;

    typedef struct {
        int    code;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ev_valid = 1'b0;
    logic [SET_W-1:0]  ev_set = '0;
    logic [LAT_W-1:0]  ev_lat = '0;
    logic              ev_fill = 1'b0;
    logic [SET_W-1:0]  q_set = SET_W'(OTHER);
    logic [1:0]        q_gran;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   edge_n = 0;
    ev_t  evq[$];
    exp_t expq[$];
    int   sc[4];
    int   prev_win = 0;
    bit   done = 0;

    fill_gran_selector #(
        .SET_W(SET_W), .LAT_W(LAT_W), .SCORE_W(SCORE_W),
        .QUANTUM_LEN(Q), .FILL_COST(FCOST)
    ) u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_set(ev_set),
        .ev_lat(ev_lat), .ev_fill(ev_fill), .q_set(q_set), .q_gran(q_gran)
    );

    always #10ns clk = ~clk;

    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_ev(input bit v, input int set, input int lat,
                           input bit fill, input int n);
        for (int i = 0; i < n; i++) begin
            ev_t e;
            e.v = v; e.set = set; e.lat = lat; e.fill = fill;
            evq.push_back(e);
        end
    endtask

    function automatic void model_add(input ev_t e);
        if (e.v && e.set < 4) begin
            sc[e.set] = sc[e.set] + e.lat + (e.fill ? FCOST : 0);
            if (sc[e.set] > MAXS) sc[e.set] = MAXS;
        end
    endfunction

    function automatic int model_win();
        int b = 0;
        for (int i = 1; i < 4; i++) if (sc[i] < sc[b]) b = i;
        return b;
    endfunction

    task automatic drive(input ev_t e);
        ev_valid = e.v;
        ev_set   = SET_W'(e.set);
        ev_lat   = LAT_W'(e.lat);
        ev_fill  = e.fill;
    endtask

    // Starts at a negedge where edge_n is a multiple of Q; ends at the next such negedge
    task automatic play_quantum(input string tag, input bit carry, input ev_t ce);
        ev_t idle;
        int  w;
        idle.v = 0; idle.set = 0; idle.lat = 0; idle.fill = 0;
        for (int s = 0; s < Q - 1; s++) begin
            if (evq.size() > 0) begin
                ev_t e = evq.pop_front();
                drive(e);
                model_add(e);
            end else begin
                drive(idle);
            end
            @(negedge clk);
        end
        // Slot sampled on the boundary edge
        if (carry) drive(ce); else drive(idle);
        q_set = SET_W'(OTHER);
        #1ns;
        check({"R5 hold before boundary, ", tag}, int'(q_gran), prev_win);
        w = model_win();
        begin
            exp_t x;
            x.code = w; x.tag = tag;
            expq.push_back(x);
        end
        prev_win = w;
        for (int i = 0; i < 4; i++) sc[i] = 0;
        if (carry) model_add(ce);
        @(negedge clk);
    endtask

    // Monitor: compare the winner just after each boundary edge
    always @(negedge clk) begin
        if (!rst && edge_n > 0 && (edge_n % Q) == 0 && expq.size() > 0) begin
            exp_t x;
            x = expq.pop_front();
            q_set = SET_W'(OTHER);
            #1ns;
            check(x.tag, int'(q_gran), x.code);
        end
    end

    initial begin
        #(200000 * 20ns);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        ev_t none;
        none.v = 0; none.set = 0; none.lat = 0; none.fill = 0;
        for (int i = 0; i < 4; i++) sc[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // Reset state, R1 and R2
        q_set = SET_W'(OTHER); #1ns;
        check("R1 reset winner", int'(q_gran), 0);
        for (int s = 0; s < 4; s++) begin
            q_set = SET_W'(s); #1ns;
            check("R2 sampler code after reset", int'(q_gran), s);
        end
        q_set = SET_W'(OTHER);

        // Quantum 1: plain latency ranking (R3, R4, R6)
        push_ev(1, 0, 100, 1, 4);
        push_ev(1, 1, 80, 0, 4);
        push_ev(1, 2, 90, 0, 4);
        push_ev(1, 3, 200, 0, 4);
        play_quantum("R3 R6 latency ranking", 0, none);

        // Quantum 2: fill cost decides (R4), junk ignored (R9), carry out (R7)
        push_ev(1, 1, 50, 1, 6);
        push_ev(1, 2, 120, 0, 3);
        push_ev(1, 0, 300, 0, 2);
        push_ev(1, 3, 100, 0, 5);
        push_ev(1, 9, 1, 0, 3);
        push_ev(0, 2, 900, 1, 2);
        begin
            ev_t c;
            c.v = 1; c.set = 3; c.lat = 10; c.fill = 1;
            play_quantum("R4 R9 fill cost outweighs latency", 1, c);
        end

        // Quantum 3: equal scores only if cleared and carried (R7, R6 tie)
        push_ev(1, 0, 100, 0, 2);
        push_ev(1, 1, 100, 0, 2);
        push_ev(1, 2, 100, 0, 2);
        push_ev(1, 3, 87, 0, 2);
        play_quantum("R7 R6 clear, carry and tie", 0, none);

        // Quantum 4: saturation (R8) with a three-way tie (R6)
        push_ev(1, 0, 1023, 1, 16);
        push_ev(1, 1, 1023, 0, 15);
        push_ev(1, 2, 1023, 0, 15);
        push_ev(1, 3, 1023, 0, 15);
        play_quantum("R8 saturation", 0, none);

        // Quantum 5: largest code wins by one
        push_ev(1, 0, 100, 0, 3);
        push_ev(1, 1, 100, 0, 3);
        push_ev(1, 2, 100, 0, 3);
        push_ev(1, 3, 100, 0, 2);
        push_ev(1, 3, 99, 0, 1);
        play_quantum("R6 largest code wins", 0, none);

        wait (expq.size() == 0);
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            q_set = SET_W'(s); #1ns;
            check("R2 sampler code after quanta", int'(q_gran), s);
        end
        q_set = SET_W'(4); #1ns;
        check("R3 set 4 follows winner", int'(q_gran), 3);
        q_set = SET_W'(255); #1ns;
        check("R3 top set follows winner", int'(q_gran), 3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule